// File: doc/BRIEF.md
# DSP Program-Switch Sequencer

This controller sits beside the instruction engine of a small sample-driven audio DSP core. It handles the move from one program to the next. When a change is requested, it mutes the left and right outputs and keeps the values last written to them. It issues a one-cycle strobe that clears the working registers, the accumulator and the previous-accumulator register. It then walks an address counter through the whole delay memory, writing one zero word per clock.

Once the memory is clean, the sequencer counts a fixed number of sample strobes before it enables the engine. The new program's first pass runs with a run flag low, so skip-on-first-pass logic can detect it. The output sample produced by that pass is replaced with zero. From the next sample on, the outputs again carry whatever was written last, even when that value dates from the previous program.

Top module: `prog_switch_seq`

## Requirements
- R1: After reset, `out_l`, `out_r` and `mem_we` are 0, and `prog_en` and `run_flag` are 1.
- R2: While running, a sample strobe copies the latest written left/right values to `out_l`/`out_r`. A write alone does not change the outputs before the next strobe.
- R3: An accepted change request forces both outputs to zero from the next cycle. They stay zero while `prog_en` is low.
- R4: `reg_clr` is high for exactly one cycle, the first cycle of the sequence.
- R5: `mem_we` is high for exactly 2^AW consecutive cycles. `mem_addr` counts up from 0 by one each cycle.
- R6: After the clear ends, `prog_en` rises right after the WAIT_SAMPLES-th sample strobe. Strobes during the clear are not counted.
- R7: `run_flag` is low while the new program's first pass runs. It rises on the strobe that ends that pass.
- R8: The strobe that ends the first pass presents zero on both outputs, whatever was written during that pass.
- R9: The following strobe presents the most recently written left/right values, whether they were written in the first pass or before the change.
- R10: A change request that arrives before the sequence completes does not restart it. Once running resumes, a new sequence starts on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chg_req | input | 1 | Program-change request, one cycle |
| smp_stb | input | 1 | One-cycle sample-period strobe |
| wr_l | input | 1 | Engine writes `wr_data` to the left channel |
| wr_r | input | 1 | Engine writes `wr_data` to the right channel |
| wr_data | input | DW | Output sample written by the engine |
| mem_we | output | 1 | Delay-memory zero-write enable |
| mem_addr | output | AW | Delay-memory clear address |
| reg_clr | output | 1 | Clear strobe for registers, accumulator and previous accumulator |
| prog_en | output | 1 | Engine may execute |
| run_flag | output | 1 | Low during the first pass of a new program |
| out_l | output | DW | Left output to converter |
| out_r | output | DW | Right output to converter |

## Verification
The assertions assume that `smp_stb` and `chg_req` are single-cycle pulses and that the engine does not write while `prog_en` is low. The bench holds every request and strobe for one step only. It issues writes only while the engine is enabled, and it keeps writes and strobes in separate cycles so the intended ordering is unambiguous. Strobe spacing is swept from every cycle to every fourth cycle so that the sample count is shown to be independent of the clock count.

// File: rtl/prog_switch_seq.sv
module prog_switch_seq #(
  parameter int DW           = 24,
  parameter int AW           = 15,
  parameter int WAIT_SAMPLES = 580
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chg_req,
  input  logic          smp_stb,
  input  logic          wr_l,
  input  logic          wr_r,
  input  logic [DW-1:0] wr_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          reg_clr,
  output logic          prog_en,
  output logic          run_flag,
  output logic [DW-1:0] out_l,
  output logic [DW-1:0] out_r
);
  localparam int CW = $clog2(WAIT_SAMPLES + 1);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};
  localparam logic [CW-1:0] WLAST = CW'(WAIT_SAMPLES - 1);

  typedef enum logic [1:0] {S_RUN, S_CLR, S_WAIT, S_FIRST} st_t;
  st_t st;
  logic [AW-1:0] addr;
  logic [CW-1:0] wcnt;
  logic          pend;
  logic [DW-1:0] hold_l, hold_r;

  assign mem_we   = (st == S_CLR);
  assign mem_addr = addr;
  assign reg_clr  = (st == S_CLR) && (addr == '0);
  assign prog_en  = (st == S_RUN) || (st == S_FIRST);
  assign run_flag = (st == S_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_RUN;
      addr   <= '0;
      wcnt   <= '0;
      pend   <= 1'b0;
      hold_l <= '0;
      hold_r <= '0;
      out_l  <= '0;
      out_r  <= '0;
    end else begin
      if (wr_l) hold_l <= wr_data;
      if (wr_r) hold_r <= wr_data;
      if (chg_req && st != S_RUN) pend <= 1'b1;
      case (st)
        S_RUN: begin
          if (chg_req || pend) begin
            st    <= S_CLR;
            addr  <= '0;
            pend  <= 1'b0;
            out_l <= '0;
            out_r <= '0;
          end else if (smp_stb) begin
            out_l <= hold_l;
            out_r <= hold_r;
          end
        end
        S_CLR: begin
          addr <= addr + 1'b1;
          if (addr == LAST) begin
            st   <= S_WAIT;
            wcnt <= '0;
          end
        end
        S_WAIT: begin
          if (smp_stb) begin
            if (wcnt == WLAST) st <= S_FIRST;
            else wcnt <= wcnt + 1'b1;
          end
        end
        default: begin
          if (smp_stb) st <= S_RUN;
        end
      endcase
    end
  end

  // R3
  muted_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |-> (out_l == '0 && out_r == '0));
  // R4
  clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_clr |=> !reg_clr);
  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) + 1'b1);
  // R5
  addr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> (mem_addr == '0 && reg_clr));
  // R6
  enable_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_en) |-> $past(smp_stb));
  // R7
  run_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_flag) |-> ($past(smp_stb) && $past(prog_en)));
endmodule

// File: tb/prog_switch_seq_tb.sv
module prog_switch_seq_tb;
  localparam int DW = 16, AW = 4, WS = 37, DEPTH = 1 << AW;
  logic clk = 0, rst_n = 0, chg_req = 0, smp_stb = 0, wr_l = 0, wr_r = 0;
  logic [DW-1:0] wr_data = '0;
  logic mem_we, reg_clr, prog_en, run_flag;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] out_l, out_r;
  int checks = 0, errors = 0;
  logic [DW-1:0] last_l = '0, last_r = '0;

  always #10 clk = ~clk;

  prog_switch_seq #(.DW(DW), .AW(AW), .WAIT_SAMPLES(WS)) u_dut (
    .clk(clk), .rst_n(rst_n), .chg_req(chg_req), .smp_stb(smp_stb),
    .wr_l(wr_l), .wr_r(wr_r), .wr_data(wr_data), .mem_we(mem_we),
    .mem_addr(mem_addr), .reg_clr(reg_clr), .prog_en(prog_en),
    .run_flag(run_flag), .out_l(out_l), .out_r(out_r));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic stb, input logic req, input logic wl,
                      input logic wrr, input logic [DW-1:0] d);
    smp_stb = stb; chg_req = req; wr_l = wl; wr_r = wrr; wr_data = d;
    @(posedge clk); #2;
    smp_stb = 0; chg_req = 0; wr_l = 0; wr_r = 0;
  endtask

  task automatic wr(input logic [DW-1:0] l, input logic [DW-1:0] r);
    step(0, 0, 1, 0, l); step(0, 0, 0, 1, r);
    last_l = l; last_r = r;
  endtask

  // expects mem_we already high (request accepted at the previous edge)
  task automatic clear_phase();
    int n = 0, nclr = 0;
    chk("R3 muted at start", int'(out_l) + int'(out_r), 0);
    while (mem_we && n < 4 * DEPTH) begin
      if (mem_addr != AW'(n)) chk("R5 address order", mem_addr, n);
      if (reg_clr) nclr++;
      n++;
      step(n % 3 == 0, 0, 0, 0, '0);
    end
    chk("R5 clear length", n, DEPTH);
    chk("R4 clear strobe count", nclr, 1);
  endtask

  task automatic wait_phase(input int gap, input bit inject);
    int k = 0, bad = 0;
    while (!prog_en && k < 10 * WS) begin
      for (int g = 1; g < gap; g++) begin
        step(0, 0, 0, 0, '0);
        if (prog_en || mem_we) bad++;
      end
      step(1, inject && k == 3, 0, 0, '0);
      if (out_l != 0 || out_r != 0) bad++;
      if (mem_we) bad++;
      k++;
    end
    chk("R6 strobes before enable", k, WS);
    chk("R3/R10 quiet during wait", bad, 0);
    chk("R7 first pass flag low", run_flag, 0);
  endtask

  initial begin
    #200000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 out_l reset", out_l, 0);
    chk("R1 mem_we reset", mem_we, 0);
    chk("R1 enabled at reset", {prog_en, run_flag}, 3);
    rst_n = 1;
    step(0, 0, 0, 0, '0);

    wr(100, 200);
    chk("R2 no change before strobe", out_l, 0);
    step(1, 0, 0, 0, '0);
    chk("R2 left after strobe", out_l, 100);
    chk("R2 right after strobe", out_r, 200);

    for (int gap = 1; gap <= 4; gap++) begin
      step(0, 1, 0, 0, '0);
      clear_phase();
      wait_phase(gap, 0);
      if (gap % 2 == 1) wr(DW'(gap * 11), DW'(gap * 13));
      step(1, 0, 0, 0, '0);
      chk("R8 first pass left zero", out_l, 0);
      chk("R8 first pass right zero", out_r, 0);
      chk("R7 flag high after pass", run_flag, 1);
      for (int g = 1; g < gap; g++) step(0, 0, 0, 0, '0);
      step(1, 0, 0, 0, '0);
      chk("R9 release left", out_l, last_l);
      chk("R9 release right", out_r, last_r);
    end

    step(0, 1, 0, 0, '0);
    clear_phase();
    wait_phase(2, 1);
    step(1, 0, 0, 0, '0);
    chk("R10 runs before restart", run_flag, 1);
    step(0, 0, 0, 0, '0);
    chk("R10 deferred restart", mem_we, 1);
    clear_phase();
    wait_phase(3, 0);
    step(1, 0, 0, 0, '0);
    step(1, 0, 0, 0, '0);
    chk("R9 value kept across two switches", out_l, last_l);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule